// File: doc/BRIEF.md
# Eight-Pin I/O Port with Debounced Pin Interrupts

This block is one general purpose I/O port of eight pins, controlled through a flat word-addressed register interface. Each pin can be a plain input, a push-pull output, an open-drain output or a quasi-bidirectional pin. The pad is modelled as three vectors: output enable, output value and weak pull-up enable. Every pad input passes through a two-flop synchronizer. A per-pin switch can cut the digital input path.

Software writes the whole output register at once, and a per-pin mask protects chosen pins from those writes. Each pin also has its own word alias. Reading the alias returns that pin's level, and writing it changes only that pin's output bit. Any pin can raise an interrupt on a rising edge, a falling edge, a high level or a low level. Status bits are cleared by writing 1, and the interrupt line is the OR of all pending status bits. An optional debounce filter sits on the interrupt path only. It samples once every 2^SEL ticks, and the tick is either every clock or a slow external enable.

Top module: `pio_port`

## Requirements
- R1: After reset every register reads 0. All pins are inputs: pad_oe_o, pad_do_o and pad_pu_o are 0. irq_o is 0.
- R2: Word 4 (level) returns the pad levels through a two-flop synchronizer. A pad change shows after the second rising clock edge and not after the first.
- R3: A 1 in word 3 (input-off) makes that pin read 0 in word 4 and in its alias, and stops it setting any status bit. Clearing the input-off bit lets the pin trigger again.
- R4: A write to word 1 (output data) changes only the pins whose bit in word 2 (mask) is 0. Masked pins keep their output value.
- R5: Word 16+n is the alias of pin n. A read returns the pin level in bit 0. A write copies wdata bit 0 into output bit n only, whatever the mask.
- R6: Word 0 holds 2 bits per pin, with pin n at bits 2n+1:2n. Code 0 is input (oe=0). Code 1 is push-pull (oe=1, do=out). Code 2 is open-drain (oe=~out, do=0).
- R7: Code 3 is quasi-bidirectional. pu=1 and do=out. The pin drives strongly (oe=1) while out is 0, and for exactly one cycle after out goes from 0 to 1; then oe=0.
- R8: When word 5 (trigger) bit n is 0, the pin is edge-triggered. Word 6 bit 16+n enables the rising edge and bit n the falling edge. An edge whose enable bit is clear sets nothing.
- R9: When word 5 bit n is 1, the pin is level-triggered. Word 6 bit 16+n enables high level and bit n low level. The status bit sets again on every cycle while the level holds.
- R10: Writing 1s to word 7 (status) clears just those bits, and 0 bits are left alone. irq_o is 1 exactly while some status bit is 1.
- R11: A 1 in word 8 (debounce enable) filters only that pin's interrupt path. A new level is taken only after two consecutive samples agree, so a one-cycle glitch is dropped while word 4 still follows the synchronized pad.
- R12: Word 9 bits 3:0 set SEL, and the filter samples every 2^SEL ticks. Bit 4 selects the tick: 0 is every clock, 1 is slow_tick_i. With SEL=4, a 12-cycle pulse is dropped and a 40-cycle pulse is taken.
- R13: Word 9 bit 5 keeps edge tracking running on all pins. When it is 0, a pin tracks edges only while one of its enables is set, so an edge that happens while the pin is disabled is reported once it is enabled. When it is 1, that edge is absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pad_i | input | 8 | Pad input levels (asynchronous) |
| pad_oe_o | output | 8 | Pad output enable |
| pad_do_o | output | 8 | Pad output value |
| pad_pu_o | output | 8 | Weak pull-up enable |
| slow_tick_i | input | 1 | Slow reference enable for the debounce counter |
| irq_o | output | 1 | OR of pending status bits |

## Verification
The assertions check four things on every cycle:
- A mask-protected output bit never changes across a port write, and an alias write touches no other output bit.
- A status bit falls only when a 1 was written to it, and a pin with its input path cut never newly sets status.
- The debounced level moves only on a sample tick, and ticks are never back to back when SEL is above 0.
- The quasi strong high never lasts beyond one cycle.

Only the bench scenarios can show the rest:
- the exact two-edge synchronizer latency;
- that level interrupts re-assert after a clear;
- the glitch and pulse-width outcomes of the filter, and the effect of its tick source;
- the different results of enabling an interrupt after a missed edge, with edge tracking kept on and with it off.

// File: rtl/pio_pkg.sv
`timescale 1ns/100ps
package pio_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HI_OFS = 16;

  typedef enum logic [1:0] {
    PM_IN = 2'd0,
    PM_PP = 2'd1,
    PM_OD = 2'd2,
    PM_QB = 2'd3
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] RA_MODE  = 5'd0;
  localparam logic [ADDR_W-1:0] RA_OUT   = 5'd1;
  localparam logic [ADDR_W-1:0] RA_MASK  = 5'd2;
  localparam logic [ADDR_W-1:0] RA_INOFF = 5'd3;
  localparam logic [ADDR_W-1:0] RA_IN    = 5'd4;
  localparam logic [ADDR_W-1:0] RA_TRIG  = 5'd5;
  localparam logic [ADDR_W-1:0] RA_IEN   = 5'd6;
  localparam logic [ADDR_W-1:0] RA_STAT  = 5'd7;
  localparam logic [ADDR_W-1:0] RA_DBEN  = 5'd8;
  localparam logic [ADDR_W-1:0] RA_DBCFG = 5'd9;
  localparam logic [ADDR_W-1:0] RA_ALIAS = 5'd16;
endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/100ps
module pio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pio_debounce.sv
`timescale 1ns/100ps
module pio_debounce #(
  parameter int unsigned N      = 8,
  parameter int unsigned SEL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     lvl_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             src_slow_i,
  input  logic             slow_tick_i,
  output logic [N-1:0]     db_o
);
  localparam int unsigned CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             base_tick, samp_tick;
  logic [N-1:0]     samp_q, db_q, agree;

  assign lim       = ~({CNT_W{1'b1}} << sel_i);
  assign base_tick = src_slow_i ? slow_tick_i : 1'b1;
  // >= so a shrinking SEL wraps at once instead of counting round
  assign samp_tick = base_tick && (cnt_q >= lim);
  assign agree     = ~(lvl_i ^ samp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (samp_tick) begin
      cnt_q <= '0;
    end else if (base_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      db_q   <= '0;
    end else if (samp_tick) begin
      samp_q <= lvl_i;
      db_q   <= (db_q & ~agree) | (lvl_i & agree);
    end
  end

  assign db_o = db_q;

  // R11
  db_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_tick |=> $stable(db_q));

  // R12
  tick_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_tick && sel_i != '0) |=> (!samp_tick || sel_i == '0));
endmodule

// File: rtl/pio_irq.sv
`timescale 1ns/100ps
module pio_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] gate_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] en_lo_i,
  input  logic [N-1:0] en_hi_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, stat_q, rise, fall, edge_hit, lvl_hit, set, keep;

  // edge history only advances on pins that are tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= (prev_q & ~act_i) | (src_i & act_i);
  end

  assign rise     = act_i &  src_i & ~prev_q;
  assign fall     = act_i & ~src_i &  prev_q;
  assign edge_hit = (rise & en_hi_i) | (fall & en_lo_i);
  assign lvl_hit  = (src_i & en_hi_i) | (~src_i & en_lo_i);
  assign set      = gate_i & ((trig_i & lvl_hit) | (~trig_i & edge_hit));
  assign keep     = stat_q & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= keep | set;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;

  // R10
  w1c_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(keep)) == $past(keep)));

  // R3
  gated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(gate_i)) == '0));
endmodule

// File: rtl/pio_pad.sv
`timescale 1ns/100ps
module pio_pad
  import pio_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*N-1:0] mode_i,
  input  logic [N-1:0]   out_i,
  output logic [N-1:0]   oe_o,
  output logic [N-1:0]   do_o,
  output logic [N-1:0]   pu_o
);
  logic [N-1:0] prev_q, boost;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= out_i;
  end

  assign boost = out_i & ~prev_q;

  for (genvar n = 0; n < N; n++) begin : g_pin
    pin_mode_e md;
    assign md = pin_mode_e'(mode_i[2*n +: 2]);

    assign oe_o[n] = (md == PM_PP)
                   | (((md == PM_OD) || (md == PM_QB)) & ~out_i[n])
                   | ((md == PM_QB) & boost[n]);
    assign do_o[n] = ((md == PM_PP) || (md == PM_QB)) & out_i[n];
    assign pu_o[n] = (md == PM_QB);

    // R7
    quasi_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (md == PM_QB && oe_o[n] && do_o[n] && $stable(mode_i)) |=> !(oe_o[n] && do_o[n]));
  end
endmodule

// File: rtl/pio_port.sv
`timescale 1ns/100ps
module pio_port
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS   = 8,
  parameter int unsigned DB_SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_do_o,
  output logic [N_PINS-1:0] pad_pu_o,
  input  logic              slow_tick_i,
  output logic              irq_o
);
  localparam int unsigned SRC_BIT = DB_SEL_W;
  localparam int unsigned ON_BIT  = DB_SEL_W + 1;

  logic [2*N_PINS-1:0] mode_q;
  logic [N_PINS-1:0]   out_q, mask_q, inoff_q, trig_q, en_lo_q, en_hi_q, dben_q;
  logic [DB_SEL_W-1:0] db_sel_q;
  logic                db_src_q, det_on_q;

  logic [N_PINS-1:0] pad_sync, in_lvl, db_lvl, irq_src, act, clr, stat;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:HI_OFS+N_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      out_q    <= '0;
      mask_q   <= '0;
      inoff_q  <= '0;
      trig_q   <= '0;
      en_lo_q  <= '0;
      en_hi_q  <= '0;
      dben_q   <= '0;
      db_sel_q <= '0;
      db_src_q <= 1'b0;
      det_on_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        RA_MODE:  mode_q  <= wdata_i[2*N_PINS-1:0];
        RA_OUT:   out_q   <= (wdata_i[N_PINS-1:0] & ~mask_q) | (out_q & mask_q);
        RA_MASK:  mask_q  <= wdata_i[N_PINS-1:0];
        RA_INOFF: inoff_q <= wdata_i[N_PINS-1:0];
        RA_TRIG:  trig_q  <= wdata_i[N_PINS-1:0];
        RA_IEN: begin
          en_lo_q <= wdata_i[N_PINS-1:0];
          en_hi_q <= wdata_i[HI_OFS +: N_PINS];
        end
        RA_DBEN:  dben_q  <= wdata_i[N_PINS-1:0];
        RA_DBCFG: begin
          db_sel_q <= wdata_i[DB_SEL_W-1:0];
          db_src_q <= wdata_i[SRC_BIT];
          det_on_q <= wdata_i[ON_BIT];
        end
        default: ;
      endcase
      // single-pin alias writes bypass the mask
      for (int n = 0; n < N_PINS; n++) begin
        if (addr_i == RA_ALIAS + ADDR_W'(n)) out_q[n] <= wdata_i[0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_MODE:  rdata_o[2*N_PINS-1:0] = mode_q;
      RA_OUT:   rdata_o[N_PINS-1:0]   = out_q;
      RA_MASK:  rdata_o[N_PINS-1:0]   = mask_q;
      RA_INOFF: rdata_o[N_PINS-1:0]   = inoff_q;
      RA_IN:    rdata_o[N_PINS-1:0]   = in_lvl;
      RA_TRIG:  rdata_o[N_PINS-1:0]   = trig_q;
      RA_IEN: begin
        rdata_o[N_PINS-1:0]          = en_lo_q;
        rdata_o[HI_OFS +: N_PINS]    = en_hi_q;
      end
      RA_STAT:  rdata_o[N_PINS-1:0]   = stat;
      RA_DBEN:  rdata_o[N_PINS-1:0]   = dben_q;
      RA_DBCFG: begin
        rdata_o[DB_SEL_W-1:0] = db_sel_q;
        rdata_o[SRC_BIT]      = db_src_q;
        rdata_o[ON_BIT]       = det_on_q;
      end
      default: ;
    endcase
    for (int n = 0; n < N_PINS; n++) begin
      if (addr_i == RA_ALIAS + ADDR_W'(n)) rdata_o[0] = in_lvl[n];
    end
  end

  pio_sync #(.W(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  assign in_lvl = pad_sync & ~inoff_q;

  pio_debounce #(.N(N_PINS), .SEL_W(DB_SEL_W)) u_db (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (in_lvl),
    .sel_i       (db_sel_q),
    .src_slow_i  (db_src_q),
    .slow_tick_i (slow_tick_i),
    .db_o        (db_lvl)
  );

  assign irq_src = (dben_q & db_lvl) | (~dben_q & in_lvl);
  assign act     = {N_PINS{det_on_q}} | en_lo_q | en_hi_q;
  assign clr     = (wr_en_i && addr_i == RA_STAT) ? wdata_i[N_PINS-1:0] : '0;

  pio_irq #(.N(N_PINS)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (irq_src),
    .act_i   (act),
    .gate_i  (~inoff_q),
    .trig_i  (trig_q),
    .en_lo_i (en_lo_q),
    .en_hi_i (en_hi_q),
    .clr_i   (clr),
    .stat_o  (stat),
    .irq_o   (irq_o)
  );

  pio_pad #(.N(N_PINS)) u_pad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_q),
    .out_i  (out_q),
    .oe_o   (pad_oe_o),
    .do_o   (pad_do_o),
    .pu_o   (pad_pu_o)
  );

  // R4
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_OUT) |=> ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q))));

  // R5
  alias_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == RA_ALIAS) |=> (out_q[N_PINS-1:1] == $past(out_q[N_PINS-1:1])));
endmodule

// File: tb/pio_port_tb_top.sv
`timescale 1ns/100ps
module pio_port_tb_top;
  import pio_pkg::*;

  localparam int OBS_RD = 0, OBS_OE = 1, OBS_DO = 2, OBS_PU = 3, OBS_IRQ = 4;

  typedef struct {
    string       req;
    int          obs;
    logic [31:0] exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  pad_i = '0;
  logic [7:0]  pad_oe_o, pad_do_o, pad_pu_o;
  logic        slow_tick_i = 1'b0;
  logic        irq_o;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #2.5 clk = ~clk;

  pio_port dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .pad_i       (pad_i),
    .pad_oe_o    (pad_oe_o),
    .pad_do_o    (pad_do_o),
    .pad_pu_o    (pad_pu_o),
    .slow_tick_i (slow_tick_i),
    .irq_o       (irq_o)
  );

  // monitor: every item pushed is compared at the next falling edge
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      case (it.obs)
        OBS_RD:  act = rdata_o;
        OBS_OE:  act = {24'd0, pad_oe_o};
        OBS_DO:  act = {24'd0, pad_do_o};
        OBS_PU:  act = {24'd0, pad_pu_o};
        default: act = {31'd0, irq_o};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: act=0x%08h exp=0x%08h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic push(input string req, input int obs, input logic [31:0] exp);
    item_t it;
    it.req = req;
    it.obs = obs;
    it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr_i = a;
    push(req, OBS_RD, exp);
    tick();
  endtask

  task automatic out_chk(input string req, input int obs, input logic [31:0] exp);
    push(req, obs, exp);
    tick();
  endtask

  task automatic do_reset();
    rst_ni      = 1'b0;
    pad_i       = '0;
    slow_tick_i = 1'b0;
    wr_en_i     = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1 reset state
    rd_chk("R1 mode", RA_MODE, 32'h0);
    rd_chk("R1 out", RA_OUT, 32'h0);
    rd_chk("R1 stat", RA_STAT, 32'h0);
    rd_chk("R1 ien", RA_IEN, 32'h0);
    out_chk("R1 oe", OBS_OE, 32'h0);
    out_chk("R1 do", OBS_DO, 32'h0);
    out_chk("R1 pu", OBS_PU, 32'h0);
    out_chk("R1 irq", OBS_IRQ, 32'h0);

    // R2 synchronizer latency
    pad_i = 8'hA5;
    idle(3);
    rd_chk("R2 level", RA_IN, 32'hA5);
    addr_i = RA_IN;
    pad_i  = 8'h5A;
    push("R2 one edge", OBS_RD, 32'hA5);
    tick();
    push("R2 two edges", OBS_RD, 32'h5A);
    tick();

    // R3 input path off
    wr(RA_INOFF, 32'h0F);
    rd_chk("R3 level masked", RA_IN, 32'h50);
    rd_chk("R3 alias masked", RA_ALIAS + 5'd1, 32'h0);
    wr(RA_TRIG, 32'hFF);
    wr(RA_IEN, 32'h0F);
    idle(4);
    rd_chk("R3 no status", RA_STAT, 32'h0);
    out_chk("R3 no irq", OBS_IRQ, 32'h0);
    wr(RA_INOFF, 32'h00);
    idle(4);
    rd_chk("R3 reenabled", RA_STAT, 32'h05);

    // R4 masked port write, R5 alias
    do_reset();
    wr(RA_OUT, 32'hFF);
    wr(RA_MASK, 32'h0F);
    wr(RA_OUT, 32'h00);
    rd_chk("R4 masked write", RA_OUT, 32'h0F);
    wr(RA_ALIAS + 5'd5, 32'h1);
    rd_chk("R5 alias set", RA_OUT, 32'h2F);
    wr(RA_ALIAS + 5'd1, 32'hFFFF_FFFE);
    rd_chk("R5 alias clear masked", RA_OUT, 32'h2D);
    pad_i = 8'h02;
    idle(3);
    rd_chk("R5 alias read hi", RA_ALIAS + 5'd1, 32'h1);
    rd_chk("R5 alias read lo", RA_ALIAS + 5'd0, 32'h0);

    // R6 drive modes: pin0 push-pull, pin1 open-drain, pin2 input, pin3 quasi
    do_reset();
    wr(RA_OUT, 32'h00);
    wr(RA_MODE, 32'hC9);
    out_chk("R6 oe low", OBS_OE, 32'h0B);
    out_chk("R6 do low", OBS_DO, 32'h00);
    out_chk("R7 pu", OBS_PU, 32'h08);
    wr(RA_OUT, 32'h07);
    out_chk("R6 oe high", OBS_OE, 32'h09);
    out_chk("R6 do high", OBS_DO, 32'h01);

    // R7 quasi strong high for one cycle
    wr_en_i = 1'b1;
    addr_i  = RA_OUT;
    wdata_i = 32'h0F;
    push("R7 boost oe", OBS_OE, 32'h09);
    push("R7 boost do", OBS_DO, 32'h09);
    tick();
    wr_en_i = 1'b0;
    push("R7 weak oe", OBS_OE, 32'h01);
    push("R7 weak do", OBS_DO, 32'h09);
    push("R7 weak pu", OBS_PU, 32'h08);
    tick();

    // R8 edges, R10 write-1-clear
    do_reset();
    wr(RA_IEN, (32'h1 << 16) | 32'h2);
    pad_i[0] = 1'b1;
    idle(4);
    rd_chk("R8 rise pin0", RA_STAT, 32'h01);
    out_chk("R10 irq set", OBS_IRQ, 32'h1);
    pad_i[1] = 1'b1;
    idle(4);
    rd_chk("R8 rise not enabled", RA_STAT, 32'h01);
    pad_i[1] = 1'b0;
    idle(4);
    rd_chk("R8 fall pin1", RA_STAT, 32'h03);
    wr(RA_STAT, 32'h02);
    rd_chk("R10 partial clear", RA_STAT, 32'h01);
    out_chk("R10 irq held", OBS_IRQ, 32'h1);
    wr(RA_STAT, 32'h01);
    rd_chk("R10 all clear", RA_STAT, 32'h00);
    out_chk("R10 irq low", OBS_IRQ, 32'h0);
    pad_i[0] = 1'b0;
    idle(4);
    rd_chk("R8 fall not enabled", RA_STAT, 32'h00);

    // R9 level
    do_reset();
    wr(RA_TRIG, 32'h04);
    wr(RA_IEN, 32'h04);
    idle(3);
    rd_chk("R9 low level", RA_STAT, 32'h04);
    wr(RA_STAT, 32'h04);
    rd_chk("R9 reassert", RA_STAT, 32'h04);
    pad_i[2] = 1'b1;
    idle(4);
    wr(RA_STAT, 32'h04);
    rd_chk("R9 level gone", RA_STAT, 32'h00);
    out_chk("R9 irq low", OBS_IRQ, 32'h0);
    wr(RA_IEN, 32'h1 << 18);
    idle(2);
    rd_chk("R9 high level", RA_STAT, 32'h04);

    // R11 debounce on interrupt path only
    do_reset();
    wr(RA_IEN, (32'h1 << 20) | (32'h1 << 21));
    wr(RA_DBEN, 32'h10);
    wr(RA_DBCFG, 32'h00);
    pad_i[5:4] = 2'b11;
    tick();
    pad_i[5:4] = 2'b00;
    idle(8);
    rd_chk("R11 glitch only raw", RA_STAT, 32'h20);
    wr(RA_STAT, 32'hFF);
    pad_i[4] = 1'b1;
    idle(2);
    rd_chk("R11 raw level", RA_IN, 32'h10);
    rd_chk("R11 filter pending", RA_STAT, 32'h00);
    rd_chk("R11 filter taken", RA_STAT, 32'h10);

    // R12 sample period and tick source
    do_reset();
    wr(RA_IEN, 32'h1 << 22);
    wr(RA_DBEN, 32'h40);
    wr(RA_DBCFG, 32'h04);
    pad_i[6] = 1'b1;
    idle(12);
    pad_i[6] = 1'b0;
    idle(60);
    rd_chk("R12 short pulse dropped", RA_STAT, 32'h00);
    pad_i[6] = 1'b1;
    idle(40);
    rd_chk("R12 long pulse taken", RA_STAT, 32'h40);
    do_reset();
    wr(RA_IEN, 32'h1 << 22);
    wr(RA_DBEN, 32'h40);
    wr(RA_DBCFG, 32'h10);
    pad_i[6] = 1'b1;
    idle(40);
    rd_chk("R12 no slow tick", RA_STAT, 32'h00);
    pad_i[6] = 1'b0;
    idle(10);
    slow_tick_i = 1'b1;
    idle(4);
    pad_i[6] = 1'b1;
    idle(10);
    rd_chk("R12 slow tick on", RA_STAT, 32'h40);

    // R13 edge tracking always on vs gated
    do_reset();
    pad_i[2] = 1'b1;
    idle(5);
    wr(RA_IEN, 32'h1 << 18);
    idle(3);
    rd_chk("R13 stale edge seen", RA_STAT, 32'h04);
    wr(RA_STAT, 32'h04);
    wr(RA_IEN, 32'h0);
    wr(RA_DBCFG, 32'h20);
    pad_i[3] = 1'b1;
    idle(5);
    wr(RA_IEN, 32'h1 << 19);
    idle(3);
    rd_chk("R13 edge absorbed", RA_STAT, 32'h00);

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule